// File: doc/BRIEF.md
# Prescaler Divider and Watchdog

This block is a timebase for a small controller. A free-running main-clock prescaler feeds a 16-bit binary up-counting divider. The divider input is either the prescaled main clock or a one-cycle pulse that marks each edge of a 32 kHz reference. A periodic tick strobe, used as an interrupt source, is taken from one of sixteen divider bits.

A 4-bit watchdog counter advances on the rising edge of one of four divider bits. Software kicks it through a clear-register write. If software fails to kick it in time, the counter wraps. The wrap sets a sticky status flag and pulses one of two reset requests: a full-chip reset, or a reset limited to the program counter and interrupt enables. Distributing the resets is left to the surrounding logic. The status flag clears only on a kick or on the hardware reset input, so it still reads back after a full reset issued by the watchdog.

Everything runs in the main clock domain. The 32 kHz reference arrives as a synchronous enable pulse.

Top module: `prescale_wdt`

## Requirements
- R1: The divider output `divCount` increments by one for each divider input pulse. Select-register bit 7 picks the input source: 0 selects the prescaled main clock, 1 selects `x32Tick`.
- R2: With select-register bits 6:4 equal to p, the prescaled main clock gives one input pulse every 2^p main-clock cycles, counting from the last divider clear.
- R3: A write to the select register, or a high `stopWake`, clears the divider and the prescaler to 0 at that clock edge. The new select value takes effect from the next cycle. `rstN` low clears all state.
- R4: With select-register bits 3:0 equal to n, `tickOut` is high for exactly one cycle, in the cycle when divider bit n goes from 0 to 1. This gives a rate of divider input / 2^(n+1). No tick is produced in a clearing cycle.
- R5: Watchdog control bits 1:0 choose the watchdog clock: divider bit 13, 11, 9 or 6 for codes 0, 1, 2 and 3. The counter advances once on each rising edge of that bit. On the 16th advance it wraps to 0, and that wrap is the overflow.
- R6: An overflow sets the status flag, which reads back at bit 7 of `wdtCtlRd`. The flag stays set until a kick or until `rstN` goes low.
- R7: On overflow, watchdog control bit 2 at 0 gives a single-cycle `fullRstReq` pulse, and at 1 gives a single-cycle `partRstReq` pulse. The two are never high together.
- R8: A clear-register write with `wdtClrWrData` = 1 clears both the watchdog counter and the status flag. This kick takes priority over an advance in the same cycle. A write with data 0 changes nothing.
- R9: While `wdtEnable` is low, the watchdog does not advance, and no reset request or status is produced.
- R10: `wdtCtlRd` returns the status flag at bit 7, the reset kind at bit 2 and the rate code at bits 1:0, with zeros elsewhere. After reset it reads 0, as do `divCount`, `tickOut` and both requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| x32Tick | input | 1 | One-cycle pulse per 32 kHz reference period |
| stopWake | input | 1 | Wake-from-stop event; clears the divider |
| wdtEnable | input | 1 | Static build-time enable for the watchdog |
| selWrEn | input | 1 | Select-register write strobe |
| selWrData | input | 8 | [7] source, [6:4] prescale code, [3:0] tick code |
| wdtCtlWrEn | input | 1 | Watchdog control write strobe |
| wdtCtlWrData | input | 3 | [2] reset kind, [1:0] rate code |
| wdtClrWrEn | input | 1 | Watchdog clear-register write strobe |
| wdtClrWrData | input | 1 | Kick bit; 1 clears counter and status |
| divCount | output | 16 | Current divider value |
| tickOut | output | 1 | Periodic tick strobe |
| wdtCtlRd | output | 8 | Watchdog control and status readback |
| fullRstReq | output | 1 | Full reset request pulse |
| partRstReq | output | 1 | Program-counter and interrupt-enable reset request pulse |

## Verification
The embedded assertions check several rules on every cycle:
- the divider is zero after a clear and otherwise holds or steps by exactly one;
- a tick only ever appears with its selected bit set;
- the status flag is sticky;
- the two reset requests are exclusive single-cycle pulses that coincide with status;
- a disabled watchdog stays silent.

Other behaviour needs the bench's scenarios: the exact overflow latency for a rate code (1984 and 15872 cycles after a clear at full rate), the prescale ratio, which request the kind bit selects, and that a clear write with data 0 has no effect. Random writes, kicks and wake events run against a cycle-accurate model.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  localparam int WDT_RATE_W = 2;
  localparam int CTL_RD_W   = 8;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic divClear;
    logic wdtKick;
    logic wdtRun;
  } strobeT;

endpackage

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int PRE_W     = 3,
  parameter int TAP_W     = 4,
  parameter int WDT_W     = 4,
  parameter int WDT_TAP_0 = 13,
  parameter int WDT_TAP_1 = 11,
  parameter int WDT_TAP_2 = 9,
  parameter int WDT_TAP_3 = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  logic                  srcX32,
  input  logic [PRE_W-1:0]      preDiv,
  input  logic [TAP_W-1:0]      tapCode,
  input  logic [WDT_RATE_W-1:0] wdtRate,
  input  logic                  x32Tick,
  output logic [DIV_W-1:0]      divCount,
  output logic                  tickOut,
  output logic                  wdtWrap
);

  localparam int PRE_CNT_W = (1 << PRE_W) - 1;

  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preMask;
  logic                 oscTick;
  logic                 divEn;
  logic [DIV_W-1:0]     riseVec;
  logic                 wdtRise;
  logic                 wdtStep;
  logic [WDT_W-1:0]     wdtCnt;

  // Prescaler mask: the low p bits are set for ratio 2^p
  always_comb begin
    for (int i = 0; i < PRE_CNT_W; i++) begin
      preMask[i] = (i < int'(preDiv));
    end
  end

  assign oscTick = ((preCnt & preMask) == preMask);
  assign divEn   = srcX32 ? x32Tick : oscTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stb.divClear) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCount <= '0;
    end else if (stb.divClear) begin
      divCount <= '0;
    end else if (divEn) begin
      divCount <= divCount + 1'b1;
    end
  end

  // Bit i rises on this step when it is 0 and every lower bit is 1
  generate
    for (genvar i = 0; i < DIV_W; i++) begin : gRise
      if (i == 0) begin : gLsb
        assign riseVec[i] = divEn & ~divCount[0];
      end else begin : gUpper
        assign riseVec[i] = divEn & ~divCount[i] & (&divCount[i-1:0]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickOut <= 1'b0;
    end else begin
      tickOut <= ~stb.divClear & riseVec[tapCode];
    end
  end

  always_comb begin
    case (wdtRate)
      2'd0:    wdtRise = riseVec[WDT_TAP_0];
      2'd1:    wdtRise = riseVec[WDT_TAP_1];
      2'd2:    wdtRise = riseVec[WDT_TAP_2];
      default: wdtRise = riseVec[WDT_TAP_3];
    endcase
  end

  assign wdtStep = stb.wdtRun & wdtRise & ~stb.divClear;
  assign wdtWrap = wdtStep & ~stb.wdtKick & (&wdtCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtCnt <= '0;
    end else if (stb.wdtKick) begin
      wdtCnt <= '0;
    end else if (wdtStep) begin
      wdtCnt <= wdtCnt + 1'b1;
    end
  end

  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.divClear |=> (divCount == '0)); // R3

  AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.divClear |=> ((divCount == $past(divCount)) ||
                       (divCount == DIV_W'($past(divCount) + 1'b1)))); // R1

  AST_TICK_TAP: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> divCount[tapCode]); // R4

  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.wdtKick |=> (wdtCnt == '0)); // R8

endmodule

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
  import pwd_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int TAP_W = 4,
  localparam int SEL_W = 1 + PRE_W + TAP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wdtEnable,
  input  logic                  stopWake,
  input  logic                  selWrEn,
  input  logic [SEL_W-1:0]      selWrData,
  input  logic                  wdtCtlWrEn,
  input  logic [WDT_RATE_W:0]   wdtCtlWrData,
  input  logic                  wdtClrWrEn,
  input  logic                  wdtClrWrData,
  input  logic                  wdtWrap,
  output strobeT                stb,
  output logic                  srcX32,
  output logic [PRE_W-1:0]      preDiv,
  output logic [TAP_W-1:0]      tapCode,
  output logic [WDT_RATE_W-1:0] wdtRate,
  output logic [CTL_RD_W-1:0]   wdtCtlRd,
  output logic                  fullRstReq,
  output logic                  partRstReq
);

  logic rstKind;
  logic wdtStatus;
  logic kick;

  assign kick = wdtClrWrEn & wdtClrWrData;

  always_comb begin
    stb          = '0;
    stb.divClear = selWrEn | stopWake;
    stb.wdtKick  = kick;
    stb.wdtRun   = wdtEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcX32  <= 1'b0;
      preDiv  <= '0;
      tapCode <= '0;
    end else if (selWrEn) begin
      {srcX32, preDiv, tapCode} <= selWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstKind <= 1'b0;
      wdtRate <= '0;
    end else if (wdtCtlWrEn) begin
      {rstKind, wdtRate} <= wdtCtlWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtStatus <= 1'b0;
    end else if (kick) begin
      wdtStatus <= 1'b0;
    end else if (wdtWrap) begin
      wdtStatus <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullRstReq <= 1'b0;
      partRstReq <= 1'b0;
    end else begin
      fullRstReq <= wdtWrap & ~rstKind;
      partRstReq <= wdtWrap & rstKind;
    end
  end

  always_comb begin
    wdtCtlRd                 = '0;
    wdtCtlRd[CTL_RD_W-1]     = wdtStatus;
    wdtCtlRd[WDT_RATE_W]     = rstKind;
    wdtCtlRd[WDT_RATE_W-1:0] = wdtRate;
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wdtStatus && !kick) |=> wdtStatus); // R6

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fullRstReq && partRstReq)); // R7

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (fullRstReq || partRstReq) |=> !(fullRstReq || partRstReq)); // R7

  AST_REQ_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (fullRstReq || partRstReq) |-> wdtStatus); // R6

  AST_WDT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEnable |=> !(fullRstReq || partRstReq)); // R9

endmodule

// File: rtl/prescale_wdt.sv
module prescale_wdt
  import pwd_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PRE_W = 3,
  parameter int TAP_W = 4,
  parameter int WDT_W = 4,
  localparam int SEL_W = 1 + PRE_W + TAP_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                x32Tick,
  input  logic                stopWake,
  input  logic                wdtEnable,
  input  logic                selWrEn,
  input  logic [SEL_W-1:0]    selWrData,
  input  logic                wdtCtlWrEn,
  input  logic [WDT_RATE_W:0] wdtCtlWrData,
  input  logic                wdtClrWrEn,
  input  logic                wdtClrWrData,
  output logic [DIV_W-1:0]    divCount,
  output logic                tickOut,
  output logic [CTL_RD_W-1:0] wdtCtlRd,
  output logic                fullRstReq,
  output logic                partRstReq
);

  strobeT                stb;
  logic                  srcX32;
  logic [PRE_W-1:0]      preDiv;
  logic [TAP_W-1:0]      tapCode;
  logic [WDT_RATE_W-1:0] wdtRate;
  logic                  wdtWrap;

  pwd_ctrl #(
    .PRE_W(PRE_W),
    .TAP_W(TAP_W)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wdtEnable    (wdtEnable),
    .stopWake     (stopWake),
    .selWrEn      (selWrEn),
    .selWrData    (selWrData),
    .wdtCtlWrEn   (wdtCtlWrEn),
    .wdtCtlWrData (wdtCtlWrData),
    .wdtClrWrEn   (wdtClrWrEn),
    .wdtClrWrData (wdtClrWrData),
    .wdtWrap      (wdtWrap),
    .stb          (stb),
    .srcX32       (srcX32),
    .preDiv       (preDiv),
    .tapCode      (tapCode),
    .wdtRate      (wdtRate),
    .wdtCtlRd     (wdtCtlRd),
    .fullRstReq   (fullRstReq),
    .partRstReq   (partRstReq)
  );

  pwd_datapath #(
    .DIV_W(DIV_W),
    .PRE_W(PRE_W),
    .TAP_W(TAP_W),
    .WDT_W(WDT_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcX32   (srcX32),
    .preDiv   (preDiv),
    .tapCode  (tapCode),
    .wdtRate  (wdtRate),
    .x32Tick  (x32Tick),
    .divCount (divCount),
    .tickOut  (tickOut),
    .wdtWrap  (wdtWrap)
  );

endmodule

// File: tb/tb_prescale_wdt.sv
module tb_prescale_wdt;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        x32Tick = 1'b0;
  logic        stopWake = 1'b0;
  logic        wdtEnable = 1'b1;
  logic        selWrEn = 1'b0;
  logic [7:0]  selWrData = '0;
  logic        wdtCtlWrEn = 1'b0;
  logic [2:0]  wdtCtlWrData = '0;
  logic        wdtClrWrEn = 1'b0;
  logic        wdtClrWrData = 1'b0;
  logic [15:0] divCount;
  logic        tickOut;
  logic [7:0]  wdtCtlRd;
  logic        fullRstReq;
  logic        partRstReq;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // Reference model state
  logic [6:0]  mPre = '0;
  logic [15:0] mCnt = '0;
  logic        mSrc = 1'b0;
  logic [2:0]  mPreDiv = '0;
  logic [3:0]  mTap = '0;
  logic [3:0]  mWdt = '0;
  logic [1:0]  mRate = '0;
  logic        mKind = 1'b0;
  logic        mStat = 1'b0;
  logic        eTick = 1'b0;
  logic        eFull = 1'b0;
  logic        ePart = 1'b0;

  prescale_wdt dut (
    .clk(clk), .rstN(rstN), .x32Tick(x32Tick), .stopWake(stopWake),
    .wdtEnable(wdtEnable), .selWrEn(selWrEn), .selWrData(selWrData),
    .wdtCtlWrEn(wdtCtlWrEn), .wdtCtlWrData(wdtCtlWrData),
    .wdtClrWrEn(wdtClrWrEn), .wdtClrWrData(wdtClrWrData),
    .divCount(divCount), .tickOut(tickOut), .wdtCtlRd(wdtCtlRd),
    .fullRstReq(fullRstReq), .partRstReq(partRstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit bitRises(logic [15:0] cnt, bit en, int k);
    logic [15:0] low;
    low = 16'((17'h1 << k) - 1);
    return en && !cnt[k] && ((cnt & low) == low);
  endfunction

  function automatic int wdtTapOf(logic [1:0] rate);
    case (rate)
      2'd0: return 13;
      2'd1: return 11;
      2'd2: return 9;
      default: return 6;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic modelEdge();
    logic [6:0] mk;
    bit oscT, divEn, clr, kick, wStep, wrap;
    for (int i = 0; i < 7; i++) mk[i] = (i < int'(mPreDiv));
    oscT  = ((mPre & mk) == mk);
    divEn = mSrc ? x32Tick : oscT;
    clr   = selWrEn | stopWake;
    kick  = wdtClrWrEn & wdtClrWrData;
    eTick = !clr && bitRises(mCnt, divEn, int'(mTap));
    wStep = wdtEnable && !clr && bitRises(mCnt, divEn, wdtTapOf(mRate));
    wrap  = wStep && !kick && (mWdt == 4'hF);
    eFull = wrap && !mKind;
    ePart = wrap && mKind;
    if (kick) mWdt = '0; else if (wStep) mWdt = mWdt + 1'b1;
    if (kick) mStat = 1'b0; else if (wrap) mStat = 1'b1;
    mPre = clr ? '0 : mPre + 1'b1;
    mCnt = clr ? '0 : (divEn ? mCnt + 1'b1 : mCnt);
    if (selWrEn) {mSrc, mPreDiv, mTap} = selWrData;
    if (wdtCtlWrEn) {mKind, mRate} = wdtCtlWrData;
  endtask

  task automatic step();
    @(posedge clk);
    cycles++;
    modelEdge();
    @(negedge clk);
    chk("R1 divCount", 32'(divCount), 32'(mCnt));
    chk("R4 tickOut", 32'(tickOut), 32'(eTick));
    chk("R7 fullRstReq", 32'(fullRstReq), 32'(eFull));
    chk("R7 partRstReq", 32'(partRstReq), 32'(ePart));
    chk("R6 wdtCtlRd", 32'(wdtCtlRd), {24'd0, mStat, 4'd0, mKind, mRate});
  endtask

  task automatic writeSel(logic [7:0] d);
    selWrEn = 1'b1; selWrData = d;
    step();
    selWrEn = 1'b0;
  endtask

  task automatic writeCtl(logic [2:0] d);
    wdtCtlWrEn = 1'b1; wdtCtlWrData = d;
    step();
    wdtCtlWrEn = 1'b0;
  endtask

  task automatic kickAndSel(logic [7:0] d);
    selWrEn = 1'b1; selWrData = d;
    wdtClrWrEn = 1'b1; wdtClrWrData = 1'b1;
    step();
    selWrEn = 1'b0; wdtClrWrEn = 1'b0; wdtClrWrData = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 reset divCount", 32'(divCount), 0);
    chk("R10 reset wdtCtlRd", 32'(wdtCtlRd), 0);
    chk("R10 reset requests", {30'd0, fullRstReq, partRstReq}, 0);
    chk("R10 reset tickOut", 32'(tickOut), 0);
    rstN = 1'b1;
    step();

    // R2: prescale 2^3 gives 10 pulses in 80 cycles
    writeSel(8'b0_011_0000);
    chk("R3 clear on select write", 32'(divCount), 0);
    repeat (80) step();
    chk("R2 prescale /8", 32'(divCount), 10);

    // R1: 32 kHz source counts only the pulses
    writeSel(8'b1_000_0000);
    for (int i = 0; i < 6; i++) begin
      x32Tick = (i % 2 == 0);
      step();
    end
    x32Tick = 1'b0;
    step();
    chk("R1 x32 source count", 32'(divCount), 3);

    // R3: wake from stop clears
    stopWake = 1'b1; step(); stopWake = 1'b0;
    chk("R3 stopWake clear", 32'(divCount), 0);

    // R4: tap 2 ticks when count reaches 4
    writeSel(8'b0_000_0010);
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R4 tick on bit2 rise", 32'(tickOut), (i == 4) ? 1 : 0);
    end

    // R5 and R7: rate 3, full reset, expect 1984 cycles
    writeCtl(3'b0_11);
    chk("R10 control readback", 32'(wdtCtlRd), 32'h03);
    kickAndSel(8'h00);
    n = 0;
    while (!fullRstReq && n < 20000) begin step(); n++; end
    chk("R5 rate3 overflow latency", n, 1984);
    chk("R7 kind0 gives full request", {30'd0, fullRstReq, partRstReq}, 2);
    chk("R6 status set", 32'(wdtCtlRd[7]), 1);
    repeat (100) step();
    chk("R6 status sticky", 32'(wdtCtlRd[7]), 1);

    // R8: data 0 write ignored, data 1 clears
    wdtClrWrEn = 1'b1; wdtClrWrData = 1'b0; step(); wdtClrWrEn = 1'b0;
    chk("R8 zero write ignored", 32'(wdtCtlRd[7]), 1);
    wdtClrWrEn = 1'b1; wdtClrWrData = 1'b1; step();
    wdtClrWrEn = 1'b0; wdtClrWrData = 1'b0;
    chk("R8 kick clears status", 32'(wdtCtlRd[7]), 0);

    // R5 and R7: rate 2, partial reset, expect 15872 cycles
    writeCtl(3'b1_10);
    kickAndSel(8'h00);
    n = 0;
    while (!partRstReq && n < 40000) begin step(); n++; end
    chk("R5 rate2 overflow latency", n, 15872);
    chk("R7 kind1 gives partial request", {30'd0, fullRstReq, partRstReq}, 1);

    // R9: disabled watchdog stays silent
    writeCtl(3'b0_11);
    kickAndSel(8'h00);
    wdtEnable = 1'b0;
    repeat (3000) step();
    chk("R9 no status when disabled", 32'(wdtCtlRd[7]), 0);
    wdtEnable = 1'b1;

    // Random mix against the model
    for (int i = 0; i < 20000; i++) begin
      x32Tick      = ($urandom % 4) == 0;
      stopWake     = ($urandom % 700) == 0;
      selWrEn      = ($urandom % 250) == 0;
      selWrData    = 8'($urandom);
      if (selWrData[7] == 1'b0) selWrData[6:4] = 3'($urandom % 3);
      wdtCtlWrEn   = ($urandom % 400) == 0;
      wdtCtlWrData = {1'($urandom), 2'b11};
      wdtClrWrEn   = ($urandom % 300) == 0;
      wdtClrWrData = 1'($urandom);
      step();
    end
    x32Tick = 1'b0; stopWake = 1'b0; selWrEn = 1'b0;
    wdtCtlWrEn = 1'b0; wdtClrWrEn = 1'b0;
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule